// File: doc/BRIEF.md
# Truncated Johnson Decade Counter with Divide-by-N Reset Latch

This block is a five-stage Johnson counter with ten one-hot decoded outputs, wrapped in a reset latch that cuts its cycle short. The count clock is a slow level input. The block samples it on the system clock, and the count moves forward one step on each low-to-high change of that level while the inhibit input is low.

A static 4-bit select picks a cycle length N from 2 to 9. When a count pulse would take the counter onto slot N, the block sets a reset latch instead. The counter then lands on slot 0, and the latch holds it there until the count clock is seen low while slot 0 is active. Any select value outside 2 to 9 leaves the full ten-count cycle in place.

A single cascade output clocks a following stage. For N of 6 or more it carries the counter's carry. For smaller N it carries decoded slot 0, because the carry does not rise at a short wrap.

Top module: `divn_decade`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the counter is at slot 0: `decOut` equals 10'b00_0000_0001 and `carryOut` is 1.
- R2: Exactly one bit of `decOut` is high in every cycle outside reset, and bit k stands for count k.
- R3: `cntClk` is sampled on each rising edge of `clk`. A rise is a sample of 1 that follows a sample of 0. If `inhibit` and `clear` are both low at that edge, the count moves from k to k+1 (9 goes to 0), and `decOut` shows the new slot after that same edge.
- R4: A `cntClk` rise sampled while `inhibit` is high leaves the count unchanged.
- R5: `carryOut` is 1 while the count is 0 to 4 and 0 while the count is 5 to 9.
- R6: With `divSel` = N and N in 2 to 9, the pulse that would make the count N makes it 0 instead. Slot N and the slots above it never appear, and slot 0 rises once every N counted pulses.
- R7: After such a forced wrap, slot 0 stays high for as long as `cntClk` stays high, and the count is held at 0. A single `clk` cycle of `cntClk` low is enough for the next rise to advance the count to 1.
- R8: A `divSel` of 0, 1 or 10 to 15 gives a plain ten-count cycle with no forced wrap.
- R9: `cascadeOut` equals `carryOut` when `divSel` is 6 to 9 or outside 2 to 9. It equals `decOut[0]` when `divSel` is 2 to 5.
- R10: `clear` high at a clock edge puts the count at 0 after that edge, even if a `cntClk` rise is sampled at the same edge, and it also releases the reset latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntClk | input | 1 | Count clock level; its sampled rises advance the count |
| inhibit | input | 1 | High blocks advancing |
| clear | input | 1 | Synchronous clear to count 0 |
| divSel | input | 4 | Static cycle length N (2 to 9 active) |
| decOut | output | 10 | One-hot decoded count |
| carryOut | output | 1 | High for counts 0 to 4 |
| cascadeOut | output | 1 | Clock for a following stage, chosen by `divSel` |

## Verification
Two things are hard to see from the ports. Slot N must never flash, and the zero slot must keep its full length while the count clock is held high after a forced wrap. The first shows only as a shortened period. The second needs long high phases followed by the shortest possible low gap. The stimulus runs every select value, legal and illegal, from a clear. It mixes pulses with random high and low lengths down to one cycle, and it adds a directed case that holds the count clock high for several cycles at the wrap and then drops it for exactly one cycle. The length of each slot-0 period is measured against N for every legal select.

// File: rtl/divn_pkg.sv
package divn_pkg;
  typedef struct packed {
    logic advance;    // step the ring one count
    logic forceZero;  // hold or put the ring at count 0
  } divn_strobe_t;
endpackage

// File: rtl/divn_johnson_path.sv
module divn_johnson_path
  import divn_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int COUNT = 2 * STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  divn_strobe_t     strb,
  output logic [COUNT-1:0] decOut,
  output logic             carryOut
);
  logic [STAGES-1:0] ringQ;
  logic [STAGES-1:0] ringNext;
  logic              legalState;

  // two-input decode of every ring state
  for (genvar k = 0; k < COUNT; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign decOut[k] = ~ringQ[STAGES-1] & ~ringQ[0];
    end else if (k < STAGES) begin : g_fill
      assign decOut[k] = ringQ[k-1] & ~ringQ[k];
    end else if (k == STAGES) begin : g_full
      assign decOut[k] = ringQ[STAGES-1] & ringQ[0];
    end else begin : g_drain
      assign decOut[k] = ~ringQ[k-STAGES-1] & ringQ[k-STAGES];
    end
  end

  assign legalState = $onehot(decOut);
  assign carryOut   = ~ringQ[STAGES-1];

  always_comb begin
    if (strb.forceZero) begin
      ringNext = '0;
    end else if (strb.advance) begin
      // an unreachable ring pattern falls back to zero (anti-lock)
      ringNext = legalState ? {ringQ[STAGES-2:0], ~ringQ[STAGES-1]} : '0;
    end else begin
      ringNext = ringQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ringQ <= '0;
    else        ringQ <= ringNext;
  end
endmodule

// File: rtl/divn_ctrl.sv
module divn_ctrl
  import divn_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4,
  localparam int COUNT       = 2 * STAGES,
  localparam int MIN_DIV     = 2,
  localparam int CARRY_SPLIT = STAGES + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntClk,
  input  logic             inhibit,
  input  logic             clear,
  input  logic [SEL_W-1:0] divSel,
  input  logic [COUNT-1:0] decOut,
  input  logic             carryOut,
  output divn_strobe_t     strb,
  output logic             cascadeOut
);
  logic cntPrev;
  logic latchQ;
  logic latchNext;
  logic riseSeen;
  logic legalDiv;
  logic useCarry;
  logic hitTerm;
  logic advance;

  assign legalDiv = (divSel >= SEL_W'(MIN_DIV)) && (divSel <= SEL_W'(COUNT - 1));
  assign useCarry = !legalDiv || (divSel >= SEL_W'(CARRY_SPLIT));

  // the slot just below N is active: the next step would reach N
  always_comb begin
    hitTerm = 1'b0;
    for (int k = MIN_DIV; k < COUNT; k++) begin
      if (divSel == SEL_W'(k)) hitTerm = decOut[k-1];
    end
  end

  assign riseSeen = cntClk & ~cntPrev;
  assign advance  = riseSeen & ~inhibit & ~latchQ & ~clear;

  always_comb begin
    strb.advance   = advance;
    strb.forceZero = clear | latchQ | (advance & hitTerm);
  end

  always_comb begin
    if (clear)                           latchNext = 1'b0;
    else if (advance && hitTerm)         latchNext = 1'b1;
    else if (latchQ && decOut[0] && !cntClk) latchNext = 1'b0;
    else                                 latchNext = latchQ;
  end

  assign cascadeOut = useCarry ? carryOut : decOut[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntPrev <= 1'b1;  // no rise on the first sample after reset
      latchQ  <= 1'b0;
    end else begin
      cntPrev <= cntClk;
      latchQ  <= latchNext;
    end
  end
endmodule

// File: rtl/divn_decade.sv
module divn_decade
  import divn_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4,
  localparam int COUNT = 2 * STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntClk,
  input  logic             inhibit,
  input  logic             clear,
  input  logic [SEL_W-1:0] divSel,
  output logic [COUNT-1:0] decOut,
  output logic             carryOut,
  output logic             cascadeOut
);
  divn_strobe_t strb;

  divn_ctrl #(.STAGES(STAGES), .SEL_W(SEL_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cntClk     (cntClk),
    .inhibit    (inhibit),
    .clear      (clear),
    .divSel     (divSel),
    .decOut     (decOut),
    .carryOut   (carryOut),
    .strb       (strb),
    .cascadeOut (cascadeOut)
  );

  divn_johnson_path #(.STAGES(STAGES)) path_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .decOut   (decOut),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/divn_decade_chk.sv
module divn_decade_chk #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4,
  localparam int COUNT = 2 * STAGES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cntClk,
  input logic             inhibit,
  input logic             clear,
  input logic [SEL_W-1:0] divSel,
  input logic [COUNT-1:0] decOut,
  input logic             carryOut,
  input logic             cascadeOut
);
  logic lastCnt;
  logic sawRise;
  logic selLegal;
  logic atTerm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lastCnt <= 1'b1;
    else        lastCnt <= cntClk;
  end

  assign sawRise  = cntClk && !lastCnt;
  assign selLegal = (divSel >= SEL_W'(2)) && (divSel <= SEL_W'(COUNT - 1));

  always_comb begin
    atTerm = 1'b0;
    for (int k = 2; k < COUNT; k++) begin
      if (divSel == SEL_W'(k)) atTerm = decOut[k-1];
    end
  end

  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(decOut));

  a_r5_carry_half: assert property (@(posedge clk) disable iff (!rst_n)
    carryOut == (|decOut[STAGES-1:0]));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sawRise && !inhibit && !clear && !atTerm && !decOut[COUNT-1])
      |=> (decOut == ($past(decOut) << 1)));

  a_r4_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !clear) |=> $stable(decOut));

  a_r6_forced_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sawRise && !inhibit && !clear && atTerm) |=> decOut[0]);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> decOut[0]);

  a_r9_cascade_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (!selLegal || divSel >= SEL_W'(STAGES + 1)) |-> cascadeOut == carryOut);

  a_r9_cascade_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (selLegal && divSel < SEL_W'(STAGES + 1)) |-> cascadeOut == decOut[0]);
endmodule

bind divn_decade divn_decade_chk #(.STAGES(STAGES), .SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cntClk     (cntClk),
  .inhibit    (inhibit),
  .clear      (clear),
  .divSel     (divSel),
  .decOut     (decOut),
  .carryOut   (carryOut),
  .cascadeOut (cascadeOut)
);

// File: tb/divn_decade_tb_top.sv
`timescale 1ns/1ps
module divn_decade_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cntClk = 1'b0;
  logic       inhibit = 1'b0;
  logic       clear = 1'b0;
  logic [3:0] divSel = 4'd0;
  logic [9:0] decOut;
  logic       carryOut;
  logic       cascadeOut;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  divn_decade dut_i (
    .clk(clk), .rst_n(rst_n), .cntClk(cntClk), .inhibit(inhibit),
    .clear(clear), .divSel(divSel), .decOut(decOut),
    .carryOut(carryOut), .cascadeOut(cascadeOut)
  );

  function automatic bit legalSel(input logic [3:0] s);
    return (s >= 4'd2) && (s <= 4'd9);
  endfunction

  function automatic int stepCount(input int cur, input logic [3:0] s);
    int nxt = (cur + 1) % 10;
    if (legalSel(s) && (cur + 1) == int'(s)) nxt = 0;
    return nxt;
  endfunction

  function automatic bit expCascade(input int cnt, input logic [3:0] s);
    if (legalSel(s) && s < 4'd6) return cnt == 0;
    return cnt < 5;
  endfunction

  task automatic checkState(input string req);
    logic [9:0] expDec = 10'(1) << expCount;
    checks++;
    if (decOut !== expDec || carryOut !== (expCount < 5) ||
        cascadeOut !== expCascade(expCount, divSel)) begin
      errors++;
      $display("FAIL %s: dec=%b carry=%b casc=%b expected dec=%b carry=%b casc=%b",
               req, decOut, carryOut, cascadeOut, expDec, (expCount < 5),
               expCascade(expCount, divSel));
    end
  endtask

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; leaves at a negedge with cntClk low
  task automatic countPulse(input int hiCyc, input int loCyc, input bit inh, input string req);
    inhibit = inh;
    cntClk  = 1'b1;
    @(negedge clk);
    if (!inh) expCount = stepCount(expCount, divSel);
    checkState(req);
    for (int i = 1; i < hiCyc; i++) begin
      @(negedge clk);
      checkState({req, " hold"});
    end
    cntClk  = 1'b0;
    inhibit = 1'b0;
    for (int i = 0; i < loCyc; i++) @(negedge clk);
  endtask

  task automatic doClear(input logic [3:0] sel);
    divSel = sel;
    clear  = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    expCount = 0;
    checkState("R10 clear");
  endtask

  task automatic measurePeriod(input logic [3:0] sel, input int expLen, input string req);
    int sinceZero = 0;
    bit prevZero;
    doClear(sel);
    prevZero = decOut[0];
    for (int p = 0; p < 3 * expLen; p++) begin
      countPulse(1 + (p % 3), 1 + (p % 2), 1'b0, req);
      sinceZero++;
      if (decOut[0] && !prevZero) begin
        checkVal({req, " period"}, sinceZero, expLen);
        sinceZero = 0;
      end else if (decOut[0]) begin
        sinceZero = 0;
      end
      prevZero = decOut[0];
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    // R1 reset state
    repeat (3) @(negedge clk);
    expCount = 0;
    checkState("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkState("R1 after reset");

    // R3 R5 R8 plain ten-count walk
    divSel = 4'd0;
    for (int p = 0; p < 12; p++) countPulse(2, 2, 1'b0, "R3 R5 R8 walk");

    // R4 inhibited pulses
    for (int p = 0; p < 3; p++) countPulse(1, 1, 1'b1, "R4 inhibit");
    countPulse(1, 1, 1'b0, "R4 after inhibit");

    // R6 R9 every legal N, R8 illegal values
    for (int n = 2; n <= 9; n++) measurePeriod(4'(n), n, "R6 R9 divide");
    measurePeriod(4'd1, 10, "R8 sel1");
    measurePeriod(4'd10, 10, "R8 sel10");
    measurePeriod(4'd15, 10, "R8 sel15");

    // R7 hold at forced wrap, then one-cycle low gap
    doClear(4'd3);
    countPulse(1, 1, 1'b0, "R7 pre");
    countPulse(1, 1, 1'b0, "R7 pre");
    countPulse(7, 1, 1'b0, "R7 wrap held");
    checkVal("R7 zero held", int'(decOut[0]), 1);
    countPulse(1, 1, 1'b0, "R7 resume");
    checkVal("R7 resumes at 1", int'(decOut[1]), 1);

    // R10 clear beats a simultaneous rise
    doClear(4'd0);
    countPulse(1, 1, 1'b0, "R10 pre");
    countPulse(1, 1, 1'b0, "R10 pre");
    clear = 1'b1; cntClk = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    expCount = 0;
    checkState("R10 clear with rise");
    @(negedge clk);
    checkState("R10 no late step");
    cntClk = 1'b0;
    @(negedge clk);

    // random mix over all select values
    for (int b = 0; b < 30; b++) begin
      doClear(4'($urandom_range(0, 15)));
      for (int p = 0; p < 25; p++)
        countPulse(int'($urandom_range(1, 3)), int'($urandom_range(1, 3)),
                   ($urandom_range(0, 4) == 0), "R2 R3 R4 R6 R9 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule